// File: doc/BRIEF.md
# Windowed Load Address Generator

This block drives the read side of a sliding-window buffer. It walks a one- or two-dimensional array held in on-chip memory and presents one read address per cycle with a read strobe. It never fetches the same word twice within an outer iteration. The first inner iteration of each outer iteration loads a set of warm-up columns plus its new columns. Every later inner iteration loads only its new columns, starting from the first column not yet fetched. A column holds `win_rows` words. These are read from the top row to the bottom row, and each step down adds the array row pitch to the address. A one-dimensional window is the case `win_rows = 1`.

After the last word of an iteration, the generator idles for a programmable number of halt cycles so that it keeps pace with a slower consumer. It then waits until the loop controller asserts issue-next. When it crosses into a new outer iteration, it raises a one-cycle flush request and moves the column origin by the outer step, so rows that overlap the previous outer iteration are fetched again. After the final word of the run, `done_o` rises and stays high until the next start.

All configuration ports are sampled on the cycle that `start_i` is accepted. Later changes on those ports have no effect until the next run. The counts `warm_cols_i`, `halt_cycles_i` and `row_pitch_i` may be zero. `new_cols_i`, `win_rows_i`, `inner_iters_i` and `outer_iters_i` must be at least one.

Top module: `winload_agen`

## Requirements
- R1: A start sampled at clock edge E0 while idle or done makes the first read strobe visible after edge E1. The first inner iteration of an outer iteration reads warm_cols+new_cols columns, one word per cycle with no gaps, beginning at the column origin.
- R2: Inner iteration i>0 of outer iteration o reads only new_cols columns, beginning at column address base + o*outer_step + warm_cols + i*new_cols.
- R3: Within a column, the win_rows addresses run from the top row to the bottom row, each one row_pitch above the one before. The next column starts one address above the top of the previous column.
- R4: After the last word of any iteration other than the final one, exactly halt_cycles idle cycles follow. Then comes one wait cycle in which issue-next is sampled.
- R5: issue-next is acted on only while waiting. A pulse during loads or halt cycles is ignored, and no strobe occurs while issue-next stays low.
- R6: At each outer boundary, flush_req_o is high for exactly one cycle, directly before the first warm-up word of the new outer iteration, and never together with a strobe.
- R7: rd_en_o is low in reset, in halt, wait and flush cycles, and while idle or done.
- R8: done_o rises the cycle after the final word of the final iteration. It stays high until the next accepted start, and it is low in the cycle after that start.
- R9: A start, or any change on the configuration ports, while a run is in progress has no effect on that run.
- R10: A halt count of zero leaves only the single wait cycle between iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (accepted when idle or done) |
| issue_next_i | input | 1 | Loop controller has issued the next iteration |
| base_addr_i | input | ADDR_W | Address of the upper-left word of the first window |
| warm_cols_i | input | CNT_W | Warm-up columns per outer iteration |
| new_cols_i | input | CNT_W | New columns per inner iteration |
| halt_cycles_i | input | CNT_W | Idle cycles after each iteration's loads |
| win_rows_i | input | CNT_W | Words per column (window height) |
| row_pitch_i | input | ADDR_W | Address distance between vertically adjacent words |
| outer_step_i | input | ADDR_W | Origin distance between adjacent outer iterations |
| inner_iters_i | input | CNT_W | Inner iterations per outer iteration |
| outer_iters_i | input | CNT_W | Outer iterations per run |
| rd_addr_o | output | ADDR_W | Read address, valid when rd_en_o is high |
| rd_en_o | output | 1 | Read strobe |
| flush_req_o | output | 1 | One-cycle buffer flush request |
| done_o | output | 1 | Run complete, held until next start |

## Verification
The bench computes the full cycle-by-cycle trace from the requirements. Word k of the run appears after k edges past the start edge plus all preceding halt, wait and flush cycles. Each flush appears one cycle before its warm-up word, and done appears one cycle after the final word. Outputs are sampled on the falling edge, so each sample reads the registers loaded by the preceding rising edge, and every cycle of the trace is compared with that expectation. In the issue-next scenario, the first strobe is due two rising edges after issue-next is raised: one edge leaves the wait state and the next registers the word. The bench samples at exactly those points.

// File: rtl/wla_pkg.sv
package wla_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HALT,
    ST_WAIT,
    ST_FLUSH,
    ST_DONE
  } ag_state_t;
endpackage

// File: rtl/wla_column_walker.sv
module wla_column_walker #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_run,
  input  logic              adv_outer,
  input  logic              begin_iter,
  input  logic              step,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] outer_step,
  input  logic [ADDR_W-1:0] row_pitch,
  input  logic [CNT_W-1:0]  rows,
  input  logic [CNT_W:0]    ncols,
  output logic [ADDR_W-1:0] word_addr,
  output logic              last_word
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  ONE_R = CNT_W'(1);
  localparam logic [CNT_W:0]    ONE_C = (CNT_W+1)'(1);

  logic [ADDR_W-1:0] outer_base;
  logic [ADDR_W-1:0] col_addr;
  logic [CNT_W-1:0]  row_idx;
  logic [CNT_W:0]    cols_left;
  logic              col_end;

  assign col_end   = (row_idx == rows - ONE_R);
  assign last_word = col_end && (cols_left == ONE_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      outer_base <= '0;
      col_addr   <= '0;
      word_addr  <= '0;
      row_idx    <= '0;
      cols_left  <= '0;
    end else if (init_run) begin
      outer_base <= start_addr;
      col_addr   <= start_addr;
      word_addr  <= start_addr;
      row_idx    <= '0;
      cols_left  <= ncols;
    end else if (adv_outer) begin
      outer_base <= outer_base + outer_step;
      col_addr   <= outer_base + outer_step;
    end else if (begin_iter) begin
      word_addr <= col_addr;
      row_idx   <= '0;
      cols_left <= ncols;
    end else if (step) begin
      if (col_end) begin
        row_idx   <= '0;
        col_addr  <= col_addr + ONE_A;
        word_addr <= col_addr + ONE_A;
        cols_left <= cols_left - ONE_C;
      end else begin
        row_idx   <= row_idx + ONE_R;
        word_addr <= word_addr + row_pitch;
      end
    end
  end

  AST_STEP_HAS_COLUMN: assert property (@(posedge clk) disable iff (rst)
    step |-> (cols_left != '0)); // R2

endmodule

// File: rtl/wla_iter_ctl.sv
module wla_iter_ctl
  import wla_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             issue_next,
  input  logic             last_word,
  input  logic [CNT_W-1:0] halt_cycles,
  input  logic [CNT_W-1:0] inner_iters,
  input  logic [CNT_W-1:0] outer_iters,
  output ag_state_t        state,
  output logic             launch,
  output logic             init_run,
  output logic             adv_outer,
  output logic             begin_iter,
  output logic             step,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ag_state_t        state_q;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] inner_left;
  logic [CNT_W-1:0] outer_left;
  logic             done_q;
  logic             final_iter;
  logic             go_on;

  assign state      = state_q;
  assign done       = done_q;
  assign launch     = start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign init_run   = launch;
  assign step       = (state_q == ST_LOAD);
  assign go_on      = (state_q == ST_WAIT) && issue_next;
  assign adv_outer  = go_on && (inner_left == ONE);
  assign begin_iter = (go_on && (inner_left != ONE)) || (state_q == ST_FLUSH);
  assign final_iter = (inner_left == ONE) && (outer_left == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      hcnt       <= '0;
      inner_left <= '0;
      outer_left <= '0;
      done_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            state_q    <= ST_LOAD;
            inner_left <= inner_iters;
            outer_left <= outer_iters;
            done_q     <= 1'b0;
          end else if (state_q == ST_DONE) begin
            done_q <= 1'b1;
          end
        end
        ST_LOAD: begin
          if (last_word) begin
            if (final_iter) begin
              state_q <= ST_DONE;
            end else if (halt_cycles != '0) begin
              state_q <= ST_HALT;
              hcnt    <= halt_cycles;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_HALT: begin
          if (hcnt == ONE) state_q <= ST_WAIT;
          else             hcnt    <= hcnt - ONE;
        end
        ST_WAIT: begin
          if (issue_next) begin
            if (inner_left == ONE) begin
              state_q    <= ST_FLUSH;
              inner_left <= inner_iters_q;
              outer_left <= outer_left - ONE;
            end else begin
              state_q    <= ST_LOAD;
              inner_left <= inner_left - ONE;
            end
          end
        end
        ST_FLUSH: state_q <= ST_LOAD;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] inner_iters_q;
  always_ff @(posedge clk) begin
    if (rst)         inner_iters_q <= '0;
    else if (launch) inner_iters_q <= inner_iters;
  end

  AST_HALT_REACHES_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && hcnt == ONE) |=> (state_q == ST_WAIT)); // R4

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && state_q == ST_HALT) |=> (inner_left == $past(inner_left))); // R9

endmodule

// File: rtl/winload_agen.sv
module winload_agen
  import wla_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              issue_next_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  warm_cols_i,
  input  logic [CNT_W-1:0]  new_cols_i,
  input  logic [CNT_W-1:0]  halt_cycles_i,
  input  logic [CNT_W-1:0]  win_rows_i,
  input  logic [ADDR_W-1:0] row_pitch_i,
  input  logic [ADDR_W-1:0] outer_step_i,
  input  logic [CNT_W-1:0]  inner_iters_i,
  input  logic [CNT_W-1:0]  outer_iters_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_en_o,
  output logic              flush_req_o,
  output logic              done_o
);
  localparam int NC_W = CNT_W + 1;

  logic [CNT_W-1:0]  warm_q, new_q, halt_q, rows_q;
  logic [ADDR_W-1:0] pitch_q, ostep_q;

  ag_state_t         state;
  logic              launch, init_run, adv_outer, begin_iter, step, done;
  logic [ADDR_W-1:0] word_addr;
  logic              last_word;
  logic [NC_W-1:0]   ncols;
  logic [CNT_W-1:0]  rows_eff;
  logic [ADDR_W-1:0] pitch_eff, ostep_eff;

  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_en_q, flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_q  <= '0;
      new_q   <= '0;
      halt_q  <= '0;
      rows_q  <= '0;
      pitch_q <= '0;
      ostep_q <= '0;
    end else if (launch) begin
      warm_q  <= warm_cols_i;
      new_q   <= new_cols_i;
      halt_q  <= halt_cycles_i;
      rows_q  <= win_rows_i;
      pitch_q <= row_pitch_i;
      ostep_q <= outer_step_i;
    end
  end

  always_comb begin
    if (launch)
      ncols = {1'b0, warm_cols_i} + {1'b0, new_cols_i};
    else if (state == ST_FLUSH)
      ncols = {1'b0, warm_q} + {1'b0, new_q};
    else
      ncols = {1'b0, new_q};
    rows_eff  = rows_q;
    pitch_eff = pitch_q;
    ostep_eff = ostep_q;
  end

  wla_iter_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .start       (start_i),
    .issue_next  (issue_next_i),
    .last_word   (last_word),
    .halt_cycles (halt_q),
    .inner_iters (inner_iters_i),
    .outer_iters (outer_iters_i),
    .state       (state),
    .launch      (launch),
    .init_run    (init_run),
    .adv_outer   (adv_outer),
    .begin_iter  (begin_iter),
    .step        (step),
    .done        (done)
  );

  wla_column_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .init_run   (init_run),
    .adv_outer  (adv_outer),
    .begin_iter (begin_iter),
    .step       (step),
    .start_addr (base_addr_i),
    .outer_step (ostep_eff),
    .row_pitch  (pitch_eff),
    .rows       (rows_eff),
    .ncols      (ncols),
    .word_addr  (word_addr),
    .last_word  (last_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr_q <= '0;
      rd_en_q   <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      rd_en_q <= step;
      flush_q <= (state == ST_FLUSH);
      if (step) rd_addr_q <= word_addr;
    end
  end

  assign rd_addr_o   = rd_addr_q;
  assign rd_en_o     = rd_en_q;
  assign flush_req_o = flush_q;
  assign done_o      = done;

  always_ff @(posedge clk) begin
    if (!rst) begin
      AST_FLUSH_EXCLUSIVE: assert (!(flush_q && rd_en_q)); // R6
    end
  end

  AST_QUIET_OUTSIDE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HALT || state == ST_WAIT || state == ST_FLUSH || state == ST_DONE) |=> !rd_en_o); // R7

  AST_NO_READ_WHILE_WAITING: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !issue_next_i) |=> (!rd_en_o && state == ST_WAIT)); // R5

  AST_FLUSH_LEADS_WARMUP: assert property (@(posedge clk) disable iff (rst)
    flush_req_o |=> rd_en_o); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o); // R8

endmodule

// File: tb/winload_agen_tb.sv
`timescale 1ns/1ps
module winload_agen_tb;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int MAXT = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          issue_next_i = 1'b1;
  logic [AW-1:0] base_addr_i = '0;
  logic [CW-1:0] warm_cols_i = '0;
  logic [CW-1:0] new_cols_i = 8'd1;
  logic [CW-1:0] halt_cycles_i = '0;
  logic [CW-1:0] win_rows_i = 8'd1;
  logic [AW-1:0] row_pitch_i = '0;
  logic [AW-1:0] outer_step_i = '0;
  logic [CW-1:0] inner_iters_i = 8'd1;
  logic [CW-1:0] outer_iters_i = 8'd1;
  logic [AW-1:0] rd_addr_o;
  logic          rd_en_o, flush_req_o, done_o;

  int checks = 0;
  int failures = 0;

  logic          e_en [MAXT];
  logic [AW-1:0] e_ad [MAXT];
  logic          e_fl [MAXT];
  logic          e_dn [MAXT];
  int            e_len;

  always #2 clk = ~clk;

  winload_agen #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .issue_next_i(issue_next_i),
    .base_addr_i(base_addr_i), .warm_cols_i(warm_cols_i), .new_cols_i(new_cols_i),
    .halt_cycles_i(halt_cycles_i), .win_rows_i(win_rows_i), .row_pitch_i(row_pitch_i),
    .outer_step_i(outer_step_i), .inner_iters_i(inner_iters_i), .outer_iters_i(outer_iters_i),
    .rd_addr_o(rd_addr_o), .rd_en_o(rd_en_o), .flush_req_o(flush_req_o), .done_o(done_o)
  );

  task automatic push(input logic en, input int ad, input logic fl, input logic dn);
    e_en[e_len] = en;
    e_ad[e_len] = AW'(ad);
    e_fl[e_len] = fl;
    e_dn[e_len] = dn;
    e_len++;
  endtask

  task automatic set_cfg(input int base, input int warm, input int nw, input int halt,
                         input int rows, input int pitch, input int ostep,
                         input int inner, input int outer);
    base_addr_i   = AW'(base);
    warm_cols_i   = CW'(warm);
    new_cols_i    = CW'(nw);
    halt_cycles_i = CW'(halt);
    win_rows_i    = CW'(rows);
    row_pitch_i   = AW'(pitch);
    outer_step_i  = AW'(ostep);
    inner_iters_i = CW'(inner);
    outer_iters_i = CW'(outer);
    e_len = 0;
    for (int o = 0; o < outer; o++) begin
      for (int i = 0; i < inner; i++) begin
        int ncol;
        int c0;
        if (o > 0 && i == 0) push(1'b0, 0, 1'b1, 1'b0);
        ncol = (i == 0) ? warm + nw : nw;
        c0 = base + o * ostep + ((i == 0) ? 0 : warm + i * nw);
        for (int c = 0; c < ncol; c++)
          for (int r = 0; r < rows; r++)
            push(1'b1, c0 + c + r * pitch, 1'b0, 1'b0);
        if (o == outer - 1 && i == inner - 1) begin
          push(1'b0, 0, 1'b0, 1'b1);
        end else begin
          for (int h = 0; h < halt; h++) push(1'b0, 0, 1'b0, 1'b0);
          push(1'b0, 0, 1'b0, 1'b0);
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s", msg);
    end
  endtask

  // Launch with the configured ports and compare every cycle of the trace.
  task automatic run_trace(input string tag, input bit busy_start);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!rd_en_o && !done_o && !flush_req_o,
          $sformatf("%s R8 launch cycle actual en=%0d dn=%0d fl=%0d expected en=0 dn=0 fl=0",
                    tag, rd_en_o, done_o, flush_req_o));
    for (int c = 0; c < e_len; c++) begin
      @(negedge clk);
      if (busy_start && c == 3) begin
        start_i = 1'b1;
        base_addr_i = 16'd999; new_cols_i = 8'd5; win_rows_i = 8'd2;
        halt_cycles_i = 8'd7; inner_iters_i = 8'd9;
      end
      if (busy_start && c == 4) start_i = 1'b0;
      check(rd_en_o == e_en[c] && flush_req_o == e_fl[c] && done_o == e_dn[c] &&
            (!e_en[c] || rd_addr_o == e_ad[c]),
            $sformatf("%s cycle %0d actual en=%0d ad=%0d fl=%0d dn=%0d expected en=%0d ad=%0d fl=%0d dn=%0d",
                      tag, c + 1, rd_en_o, rd_addr_o, flush_req_o, done_o,
                      e_en[c], e_ad[c], e_fl[c], e_dn[c]));
    end
  endtask

  task automatic t_reset();
    check(!rd_en_o && !flush_req_o && !done_o,
          $sformatf("R7 reset state actual en=%0d fl=%0d dn=%0d expected 0 0 0",
                    rd_en_o, flush_req_o, done_o));
  endtask

  task automatic t_line_no_halt();   // R1 R2 R10
    set_cfg(100, 2, 1, 0, 1, 0, 0, 4, 1);
    run_trace("R1/R2/R10 1d", 1'b0);
  endtask

  task automatic t_line_halt();      // R4
    set_cfg(300, 1, 2, 3, 1, 7, 0, 3, 1);
    run_trace("R4 halt", 1'b0);
  endtask

  task automatic t_grid();           // R3 R6
    set_cfg(200, 2, 1, 1, 3, 10, 10, 3, 3);
    run_trace("R3/R6 2d", 1'b0);
  endtask

  task automatic t_done_hold();      // R8
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(done_o && !rd_en_o,
            $sformatf("R8 done hold actual dn=%0d en=%0d expected dn=1 en=0", done_o, rd_en_o));
    end
  endtask

  task automatic t_busy_start();     // R9
    set_cfg(40, 1, 1, 2, 2, 16, 3, 3, 2);
    run_trace("R9 busy start", 1'b1);
  endtask

  task automatic t_issue_wait();     // R5
    bit quiet;
    set_cfg(50, 2, 1, 0, 1, 1, 0, 3, 1);
    issue_next_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      issue_next_i = (c == 1);
      check(rd_en_o && rd_addr_o == AW'(49 + c),
            $sformatf("R5 warm word %0d actual en=%0d ad=%0d expected en=1 ad=%0d",
                      c, rd_en_o, rd_addr_o, 49 + c));
    end
    issue_next_i = 1'b0;
    quiet = 1'b1;
    for (int c = 4; c <= 23; c++) begin
      @(negedge clk);
      if (rd_en_o || done_o) quiet = 1'b0;
    end
    check(quiet, $sformatf("R5 held wait actual quiet=%0d expected 1", quiet));
    issue_next_i = 1'b1;
    @(negedge clk);
    issue_next_i = 1'b0;
    check(!rd_en_o, $sformatf("R5 leave wait actual en=%0d expected 0", rd_en_o));
    @(negedge clk);
    check(rd_en_o && rd_addr_o == 16'd53,
          $sformatf("R5 resumed word actual en=%0d ad=%0d expected en=1 ad=53", rd_en_o, rd_addr_o));
    quiet = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rd_en_o || done_o) quiet = 1'b0;
    end
    check(quiet, $sformatf("R5 second wait actual quiet=%0d expected 1", quiet));
    issue_next_i = 1'b1;
    @(negedge clk);
    check(!rd_en_o, $sformatf("R5 leave wait 2 actual en=%0d expected 0", rd_en_o));
    @(negedge clk);
    check(rd_en_o && rd_addr_o == 16'd54,
          $sformatf("R5 last word actual en=%0d ad=%0d expected en=1 ad=54", rd_en_o, rd_addr_o));
    @(negedge clk);
    check(done_o && !rd_en_o,
          $sformatf("R8 done after last actual dn=%0d en=%0d expected dn=1 en=0", done_o, rd_en_o));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_line_no_halt();
    t_done_hold();
    t_line_halt();
    t_grid();
    t_done_hold();
    t_busy_start();
    t_issue_wait();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule